// File: doc/BRIEF.md
# Infrared UART Status and Interrupt Unit

This unit is the register and flag front end of a byte-wide UART that carries infrared SIR traffic. A CPU reaches it over a 16-bit register bus with single-cycle accesses. The serial shifters sit outside the unit and talk to it through simple strobes. On the transmit side a byte is handed to the shifter and the unit tracks when the transmit buffer and the shift register are empty. On the receive side the unit latches an arriving byte together with its error flags.

An interrupt line combines every status flag with its own mask bit. A frame-processing register latches end-of-frame and frame-error events and has a write-to-clear companion register. A separate pulse-width error flag has its own clear bit.

Register word addresses are 0 control, 1 status, 2 interrupt mask, 3 transmit data (write), 4 receive data (read), 5 frame, 6 frame flag clear (write), 7 infrared control (write) and 8 infrared status (read). Unmapped reads return zero. Writes take effect on the clock edge. Read data is combinational from the address, and the side effects of a read happen on that same edge.

Top module: `irUartStatus`

## Requirements
- R1: After reset the status register reads 0x0003, and the control, mask, frame and infrared status registers read 0. `irq` is 0 and `txComplete` is 1.
- R2: A write to address 3 clears status bit 0 (transmit buffer empty) and presents the byte on `txByte`. `txValid` equals control bit 0 (transmit enable) AND NOT bit 0. A `txTake` while `txValid` is high sets bit 0 and clears bit 1 (shift empty). A `txShiftDone` sets bit 1.
- R3: `txComplete` is high only when status bits 0 and 1 are both set.
- R4: A control write with bit 2 set discards a pending transmit byte, so bit 0 is set and `txValid` drops. Control bit 2 always reads back 0, and bits 1:0 read back as written.
- R5: `rxStrobe` with control bit 1 (receive enable) set and the buffer free stores `rxByte` and sets status bit 2 (receive full). It sets bit 3 (parity) from `rxParErr` and bit 4 (framing) from `rxFrmErr`. Bit 6 (sum) is the OR of bits 3, 4 and 5.
- R6: A byte arriving while bit 2 is set sets bit 5 (overrun), and the byte is discarded. The stored byte is unchanged.
- R7: A read of address 4 returns the stored byte in bits 7:0 and clears status bits 2 to 6. If a byte arrives in the same cycle, it is accepted after the clear.
- R8: `rxStrobe` while receive enable is 0 has no effect on the status or the stored byte.
- R9: `irq` is the OR over status bits of (status AND mask). Only mask bits 0, 1, 2 and 6 are writable, and the other mask bits read 0.
- R10: Frame register bit 0 is a read/write enable. `frameErrIn` sets bit 8 and `eofIn` sets bit 9, but only while the enable is set. A write of 0xFFFF to address 6 clears bits 8 and 9, and any other value there has no effect.
- R11: `pulseErrIn` sets infrared status bit 0. A write to address 7 with bit 0 set clears it, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register word address |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data (combinational) |
| txByte | output | 8 | Byte offered to the transmit shifter |
| txValid | output | 1 | A byte is pending and transmit is enabled |
| txTake | input | 1 | Shifter loads the pending byte |
| txShiftDone | input | 1 | Shifter has sent its last bit |
| txComplete | output | 1 | Buffer and shifter both empty |
| txEn | output | 1 | Transmit enable to the shifter |
| rxEn | output | 1 | Receive enable to the shifter |
| rxStrobe | input | 1 | A received byte is presented |
| rxByte | input | 8 | Received byte |
| rxParErr | input | 1 | Parity error on this byte |
| rxFrmErr | input | 1 | Framing error on this byte |
| frameErrIn | input | 1 | Frame error event from frame logic |
| eofIn | input | 1 | End-of-frame event from frame logic |
| pulseErrIn | input | 1 | Receive pulse-width error event |
| irq | output | 1 | Masked interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- a transmit-data write empties nothing and clears the buffer-empty flag;
- an arrival into a full buffer raises overrun and keeps the stored byte;
- a receive-data read clears the full and error flags;
- a disabled receiver leaves state untouched;
- an all-zero mask keeps `irq` low;
- a flag-clear write removes both frame flags.

Only the bench scenarios show the remaining behaviour:
- the exact status word after long mixed sequences of transmit, take, shift-done, arrival and read;
- the same-cycle read-and-arrival ordering;
- the discarding of a pending byte;
- the rule that only all ones clears the frame flags;
- the enable gating of frame events.

// File: rtl/irusPkg.sv
package irusPkg;
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_STAT   = 4'd1;
  localparam logic [3:0] A_MASK   = 4'd2;
  localparam logic [3:0] A_TXDATA = 4'd3;
  localparam logic [3:0] A_RXDATA = 4'd4;
  localparam logic [3:0] A_FRAME  = 4'd5;
  localparam logic [3:0] A_FLGCLR = 4'd6;
  localparam logic [3:0] A_IRCTRL = 4'd7;
  localparam logic [3:0] A_IRSTAT = 4'd8;

  localparam int STAT_W = 7;
  localparam logic [STAT_W-1:0] MASK_WRITABLE = 7'b1000111;

  typedef struct packed {
    logic wrTx;
    logic txClr;
    logic rdRx;
    logic flagClr;
    logic pulseClr;
  } irusStrobe_t;
endpackage

// File: rtl/irusCtrl.sv
module irusCtrl
  import irusPkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [3:0]        busAddr,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  output irusStrobe_t       st,
  output logic              txEn,
  output logic              rxEn,
  output logic              frmEn,
  output logic [STAT_W-1:0] maskReg,
  input  logic [STAT_W-1:0] stat,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              frameErr,
  input  logic              eof,
  input  logic              pulseErr
);
  localparam logic [BUS_W-1:0] ALL_ONES = '1;

  logic wrAcc, rdAcc;
  assign wrAcc = busSel && busWr;
  assign rdAcc = busSel && !busWr;

  always_comb begin
    st          = '0;
    st.wrTx     = wrAcc && (busAddr == A_TXDATA);
    st.txClr    = wrAcc && (busAddr == A_CTRL) && busWData[2];
    st.rdRx     = rdAcc && (busAddr == A_RXDATA);
    st.flagClr  = wrAcc && (busAddr == A_FLGCLR) && (busWData == ALL_ONES);
    st.pulseClr = wrAcc && (busAddr == A_IRCTRL) && busWData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
      frmEn   <= 1'b0;
      maskReg <= '0;
    end else if (wrAcc) begin
      if (busAddr == A_CTRL) begin
        txEn <= busWData[0];
        rxEn <= busWData[1];
      end
      if (busAddr == A_MASK)  maskReg <= busWData[STAT_W-1:0] & MASK_WRITABLE;
      if (busAddr == A_FRAME) frmEn   <= busWData[0];
    end
  end

  always_comb begin
    busRData = '0;
    if (rdAcc) begin
      case (busAddr)
        A_CTRL:   busRData[1:0] = {rxEn, txEn};
        A_STAT:   busRData[STAT_W-1:0] = stat;
        A_MASK:   busRData[STAT_W-1:0] = maskReg;
        A_RXDATA: busRData[BYTE_W-1:0] = rxData;
        A_FRAME: begin
          busRData[0] = frmEn;
          busRData[8] = frameErr;
          busRData[9] = eof;
        end
        A_IRSTAT: busRData[0] = pulseErr;
        default:  busRData = '0;
      endcase
    end
  end
endmodule

// File: rtl/irusFlags.sv
module irusFlags
  import irusPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irusStrobe_t       st,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic              frmEn,
  input  logic              txTake,
  input  logic              txShiftDone,
  input  logic              rxStrobe,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              frameErrIn,
  input  logic              eofIn,
  input  logic              pulseErrIn,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              txComplete,
  output logic [STAT_W-1:0] stat,
  output logic [BYTE_W-1:0] rxData,
  output logic              frameErr,
  output logic              eof,
  output logic              pulseErr
);
  logic txBufEmpty, txShiftEmpty;
  logic rxFull, rxPar, rxFrm, rxOverrun;
  logic takeNow, rxAccept, rxFree;

  assign txValid    = !txBufEmpty && txEn;
  assign takeNow    = txTake && txValid;
  assign txComplete = txBufEmpty && txShiftEmpty;
  assign rxAccept   = rxStrobe && rxEn;
  assign rxFree     = !rxFull || st.rdRx;

  // transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBufEmpty   <= 1'b1;
      txShiftEmpty <= 1'b1;
      txByte       <= '0;
    end else begin
      if (st.wrTx) begin
        txBufEmpty <= 1'b0;
        txByte     <= wrByte;
      end else if (st.txClr || takeNow) begin
        txBufEmpty <= 1'b1;
      end
      if (takeNow)          txShiftEmpty <= 1'b0;
      else if (txShiftDone) txShiftEmpty <= 1'b1;
    end
  end

  // receive side: a read clears first, then an arrival may land
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      rxPar     <= 1'b0;
      rxFrm     <= 1'b0;
      rxOverrun <= 1'b0;
      rxData    <= '0;
    end else begin
      if (st.rdRx) begin
        rxFull    <= 1'b0;
        rxPar     <= 1'b0;
        rxFrm     <= 1'b0;
        rxOverrun <= 1'b0;
      end
      if (rxAccept) begin
        if (rxFree) begin
          rxFull <= 1'b1;
          rxData <= rxByte;
          rxPar  <= rxParErr;
          rxFrm  <= rxFrmErr;
        end else begin
          rxOverrun <= 1'b1;
        end
      end
    end
  end

  // frame and pulse-width flags: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameErr <= 1'b0;
      eof      <= 1'b0;
      pulseErr <= 1'b0;
    end else begin
      if (frmEn && frameErrIn) frameErr <= 1'b1;
      else if (st.flagClr)     frameErr <= 1'b0;
      if (frmEn && eofIn)      eof <= 1'b1;
      else if (st.flagClr)     eof <= 1'b0;
      if (pulseErrIn)          pulseErr <= 1'b1;
      else if (st.pulseClr)    pulseErr <= 1'b0;
    end
  end

  assign stat = {rxPar | rxFrm | rxOverrun, rxOverrun, rxFrm, rxPar,
                 rxFull, txShiftEmpty, txBufEmpty};

  p_tx_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.wrTx |=> !txBufEmpty);

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxAccept && rxFull && !st.rdRx) |=> (rxOverrun && $stable(rxData)));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdRx && !rxAccept) |=> (!rxFull && !rxOverrun && !rxPar && !rxFrm));

  p_rx_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && !rxEn && !st.rdRx) |=> ($stable(rxFull) && $stable(rxData)));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.flagClr && !frameErrIn && !eofIn) |=> (!frameErr && !eof));
endmodule

// File: rtl/irUartStatus.sv
module irUartStatus
  import irusPkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [3:0]        busAddr,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  input  logic              txTake,
  input  logic              txShiftDone,
  output logic              txComplete,
  output logic              txEn,
  output logic              rxEn,
  input  logic              rxStrobe,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              frameErrIn,
  input  logic              eofIn,
  input  logic              pulseErrIn,
  output logic              irq
);
  irusStrobe_t       st;
  logic              frmEn, frameErr, eof, pulseErr;
  logic [STAT_W-1:0] maskReg, stat;
  logic [BYTE_W-1:0] rxData;

  irusCtrl #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .st(st), .txEn(txEn), .rxEn(rxEn), .frmEn(frmEn), .maskReg(maskReg),
    .stat(stat), .rxData(rxData), .frameErr(frameErr), .eof(eof),
    .pulseErr(pulseErr)
  );

  irusFlags #(.BYTE_W(BYTE_W)) uFlags (
    .clk(clk), .rstN(rstN), .st(st), .wrByte(busWData[BYTE_W-1:0]),
    .txEn(txEn), .rxEn(rxEn), .frmEn(frmEn), .txTake(txTake),
    .txShiftDone(txShiftDone), .rxStrobe(rxStrobe), .rxByte(rxByte),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .frameErrIn(frameErrIn),
    .eofIn(eofIn), .pulseErrIn(pulseErrIn), .txByte(txByte),
    .txValid(txValid), .txComplete(txComplete), .stat(stat),
    .rxData(rxData), .frameErr(frameErr), .eof(eof), .pulseErr(pulseErr)
  );

  assign irq = |(stat & maskReg);

  p_zero_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq);
endmodule

// File: tb/tb_irUartStatus.sv
module tb_irUartStatus;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 0, busWr = 0;
  logic [3:0]  busAddr = 0;
  logic [15:0] busWData = 0;
  logic [15:0] busRData;
  logic [7:0]  txByte;
  logic        txValid, txComplete, txEn, rxEn, irq;
  logic        txTake = 0, txShiftDone = 0, rxStrobe = 0;
  logic [7:0]  rxByte = 0;
  logic        rxParErr = 0, rxFrmErr = 0;
  logic        frameErrIn = 0, eofIn = 0, pulseErrIn = 0;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       mTbe, mTsbe, mFull, mPar, mFrm, mOve;
  logic [7:0] mData, mTx;
  logic [1:0] mCtrl;
  logic [6:0] mMask;

  always #10 clk = ~clk;

  irUartStatus dut (.*);

  function automatic logic [15:0] expStat();
    logic [6:0] s;
    s = {mPar | mFrm | mOve, mOve, mFrm, mPar, mFull, mTsbe, mTbe};
    return {9'd0, s};
  endfunction

  function automatic logic expIrq();
    return |(expStat() & {9'd0, mMask});
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRData;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic rxIn(logic [7:0] b, logic p, logic f);
    @(negedge clk);
    rxStrobe = 1; rxByte = b; rxParErr = p; rxFrmErr = f;
    @(negedge clk);
    rxStrobe = 0; rxParErr = 0; rxFrmErr = 0;
  endtask

  task automatic modelRx(logic [7:0] b, logic p, logic f);
    if (mCtrl[1]) begin
      if (mFull) mOve = 1;
      else begin mFull = 1; mData = b; mPar = p; mFrm = f; end
    end
  endtask

  task automatic pulseTake();
    @(negedge clk); txTake = 1; @(negedge clk); txTake = 0;
  endtask

  task automatic pulseDone();
    @(negedge clk); txShiftDone = 1; @(negedge clk); txShiftDone = 0;
  endtask

  task automatic checkAll(string req);
    logic [15:0] d;
    busRead(4'd1, d);
    chk(req, d, expStat());
    chk(req, {15'd0, irq}, {15'd0, expIrq()});
    chk("R3 txComplete", {15'd0, txComplete}, {15'd0, mTbe & mTsbe});
    chk("R2 txValid", {15'd0, txValid}, {15'd0, !mTbe & mCtrl[0]});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    mTbe = 1; mTsbe = 1; mFull = 0; mPar = 0; mFrm = 0; mOve = 0;
    mData = 0; mTx = 0; mCtrl = 0; mMask = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    busRead(4'd1, d); chk("R1 status", d, 16'h0003);
    busRead(4'd0, d); chk("R1 ctrl", d, 16'h0000);
    busRead(4'd2, d); chk("R1 mask", d, 16'h0000);
    busRead(4'd5, d); chk("R1 frame", d, 16'h0000);
    busRead(4'd8, d); chk("R1 irstat", d, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 txComplete", {15'd0, txComplete}, 16'd1);

    // R9 mask writable bits
    busWrite(4'd2, 16'hFFFF); mMask = 7'h47;
    busRead(4'd2, d); chk("R9 mask readback", d, 16'h0047);
    chk("R9 irq tbe", {15'd0, irq}, 16'd1);

    // R8 receiver disabled
    rxIn(8'hA5, 1, 1);
    busRead(4'd1, d); chk("R8 ignored status", d, 16'h0003);
    busRead(4'd4, d); chk("R8 ignored data", d, 16'h0000);

    // R2/R3/R4 transmit flow
    busWrite(4'd0, 16'h0003); mCtrl = 2'b11;
    busRead(4'd0, d); chk("R4 ctrl readback", d, 16'h0003);
    busWrite(4'd3, 16'h005A); mTbe = 0; mTx = 8'h5A;
    chk("R2 txByte", {8'd0, txByte}, 16'h005A);
    checkAll("R2 after write");
    busWrite(4'd0, 16'h0007); mTbe = 1;
    busRead(4'd0, d); chk("R4 clear bit reads 0", d, 16'h0003);
    checkAll("R4 after discard");
    busWrite(4'd3, 16'h00C3); mTbe = 0;
    pulseTake(); mTbe = 1; mTsbe = 0;
    checkAll("R3 shifting");
    pulseDone(); mTsbe = 1;
    checkAll("R3 complete");

    // R5/R6/R7 receive
    rxIn(8'h3C, 1, 0); modelRx(8'h3C, 1, 0);
    checkAll("R5 stored");
    rxIn(8'h99, 0, 0); modelRx(8'h99, 0, 0);
    checkAll("R6 overrun");
    busRead(4'd4, d); chk("R6 data kept", d, 16'h003C);
    mFull = 0; mPar = 0; mFrm = 0; mOve = 0;
    checkAll("R7 cleared");
    rxIn(8'h11, 0, 1); modelRx(8'h11, 0, 1);
    // R7 same-cycle read and arrival
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 4'd4; rxStrobe = 1; rxByte = 8'h77;
    #1 chk("R7 read old byte", busRData, 16'h0011);
    @(negedge clk);
    busSel = 0; rxStrobe = 0;
    mFull = 1; mData = 8'h77; mPar = 0; mFrm = 0; mOve = 0;
    checkAll("R7 arrival after clear");
    busRead(4'd4, d); chk("R7 new byte", d, 16'h0077);
    mFull = 0;

    // R10 frame flags
    @(negedge clk); frameErrIn = 1; eofIn = 1; @(negedge clk); frameErrIn = 0; eofIn = 0;
    busRead(4'd5, d); chk("R10 disabled events", d, 16'h0000);
    busWrite(4'd5, 16'h0001);
    @(negedge clk); frameErrIn = 1; eofIn = 1; @(negedge clk); frameErrIn = 0; eofIn = 0;
    busRead(4'd5, d); chk("R10 latched", d, 16'h0301);
    busWrite(4'd6, 16'hFFFE);
    busRead(4'd5, d); chk("R10 partial no effect", d, 16'h0301);
    busWrite(4'd6, 16'hFFFF);
    busRead(4'd5, d); chk("R10 cleared", d, 16'h0001);

    // R11 pulse-width error
    @(negedge clk); pulseErrIn = 1; @(negedge clk); pulseErrIn = 0;
    busRead(4'd8, d); chk("R11 set", d, 16'h0001);
    busWrite(4'd7, 16'h0000);
    busRead(4'd8, d); chk("R11 kept", d, 16'h0001);
    busWrite(4'd7, 16'h0001);
    busRead(4'd8, d); chk("R11 cleared", d, 16'h0000);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] b;
      logic p, f;
      logic [15:0] w;
      op = $urandom_range(0, 6);
      b  = 8'($urandom);
      p  = ($urandom_range(0, 3) == 0);
      f  = ($urandom_range(0, 3) == 0);
      case (op)
        0: begin busWrite(4'd3, {8'd0, b}); mTbe = 0; mTx = b; end
        1: begin
          pulseTake();
          if (!mTbe && mCtrl[0]) begin mTbe = 1; mTsbe = 0; end
        end
        2: begin pulseDone(); mTsbe = 1; end
        3: begin rxIn(b, p, f); modelRx(b, p, f); end
        4: begin
          busRead(4'd4, w);
          chk("R7 random read", w, {8'd0, mData});
          mFull = 0; mPar = 0; mFrm = 0; mOve = 0;
        end
        5: begin
          w = {13'd0, ($urandom_range(0, 4) == 0), 2'($urandom)};
          busWrite(4'd0, w);
          mCtrl = w[1:0];
          if (w[2]) mTbe = 1;
        end
        default: begin
          w = 16'($urandom);
          busWrite(4'd2, w); mMask = w[6:0] & 7'h47;
        end
      endcase
      if (!mTbe) chk("R2 random txByte", {8'd0, txByte}, {8'd0, mTx});
      checkAll("R5 R9 random status");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule